// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side state machine that tracks the operating state of a host-to-device interface. It has six states: a power-on reset state, a ready state, a fully active state and three reduced-power states. The three reduced-power states are a device-suspended state, a low-power state from which the device may drop further, and a state in which both sides are suspended and the link is unavailable. The current state decides whether the host may touch the device's registers and whether data transfers are granted.

The host drives a small register port. It writes a requested state code into a control register, reads the state and a sticky error flag from a status register, and programs a bank of context registers. Start-up follows a fixed handshake. The device leaves reset only when its internal boot signal is asserted. The host then waits until the status register shows the ready state, programs the context registers, requests the active state and polls until the active state is reported.

A request for a transition that is not allowed leaves the state unchanged and sets the error flag. A reset request is honoured from any state. It returns to the reset state at the next clock edge, clears the context registers and clears the error flag.

Top module: `lpwr_state_ctrl`

## Requirements
- R1: While `rstN` is low, and after it is released, `curState` is the reset code 0, `errFlag` is 0, `xferGrant` is 0 and `regRdData` is 0.
- R2: In the reset state the state moves to ready (code 1) at the first clock edge that samples `bootDone` high. While `bootDone` is low the state stays reset. No other state can follow reset.
- R3: In the reset state, writes to any register are dropped. A control write changes neither the state nor the error flag, and a context write is not visible after the device becomes ready.
- R4: In the reset state, every read returns zero.
- R5: The state codes are ready=1, active=2, suspended=3, low-power=4 and link-off=5. A write to control address 0 with bits [2:0] set to a target code changes the state at that clock edge when the move is legal. The legal moves are ready to active; active to suspended, low-power or link-off; suspended to active or link-off; low-power to active or link-off; link-off to active.
- R6: A control write to a target other than 0 or the current state that is not legal leaves the state unchanged and sets `errFlag`. Codes 6 and 7 are always illegal. Requesting the current state changes nothing.
- R7: `errFlag` stays set until a reset request or `rstN` clears it. Later legal requests do not clear it.
- R8: A control write with code 0 from any state other than reset puts the state to reset at that clock edge. It also clears `errFlag` and all context registers.
- R9: Context registers sit at addresses 2 up to 2**ADDR_W-1. They take writes in the ready and active states and ignore writes in the three reduced-power states. They read back in every state except reset.
- R10: `xferGrant` equals `xferReq` in the active state and is 0 in every other state.
- R11: Status address 1 reads {xfer-enabled bit 4, error bit 3, state bits [2:0]} with the upper bits zero. The control address reads zero.
- R12: The start-up handshake works as follows: boot to ready, program the context registers, request active, then read the active code from the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootDone | input | 1 | Device internal boot complete, allows leaving reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| xferReq | input | 1 | Data transfer request |
| xferGrant | output | 1 | Data transfer granted |
| curState | output | 3 | Current state code |
| errFlag | output | 1 | Sticky illegal-request flag |

## Verification
The bench builds the block with ADDR_W=2 and DATA_W=8. This gives two context registers, which is enough to show a write landing in one register while the other is dropped. It also keeps the bank small, so every context value can be read back after each phase. With only six states and eight request codes, the bench sweeps all 48 pairs of starting state and requested code. For each pair it computes the expected state and error flag from the legal-move table. It then adds targeted sequences for sticky errors, context gating per state, reset-state access and the start-up handshake.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_READY = 3'd1,
    ST_ACT   = 3'd2,
    ST_SUSP  = 3'd3,
    ST_LOWP  = 3'd4,
    ST_OFF   = 3'd5
  } lpState_t;

  typedef struct packed {
    logic ctxWe;
    logic ctxClr;
    logic rdOpen;
  } lpStrobe_t;

  function automatic logic moveLegal(lpState_t fromSt, logic [2:0] toCode);
    logic ok;
    ok = 1'b0;
    case (fromSt)
      ST_READY: ok = (toCode == ST_ACT);
      ST_ACT:   ok = (toCode == ST_SUSP) || (toCode == ST_LOWP) || (toCode == ST_OFF);
      ST_SUSP:  ok = (toCode == ST_ACT) || (toCode == ST_OFF);
      ST_LOWP:  ok = (toCode == ST_ACT) || (toCode == ST_OFF);
      ST_OFF:   ok = (toCode == ST_ACT);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/lpwr_fsm.sv
module lpwr_fsm
  import lpwr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootDone,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              xferReq,
  output lpState_t          state,
  output logic              errFlag,
  output logic              xferGrant,
  output lpStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] CTX_BASE  = ADDR_W'(2);

  logic       ctrlWr;
  logic [2:0] reqCode;
  logic       ctxWritable;

  assign reqCode     = regWrData[2:0];
  assign ctrlWr      = regWrEn && (regAddr == CTRL_ADDR) && (state != ST_RESET);
  assign ctxWritable = (state == ST_READY) || (state == ST_ACT);

  always_comb begin
    strobe.ctxWe  = regWrEn && (regAddr >= CTX_BASE) && ctxWritable;
    strobe.ctxClr = ctrlWr && (reqCode == ST_RESET);
    strobe.rdOpen = (state != ST_RESET);
  end

  assign xferGrant = xferReq && (state == ST_ACT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RESET;
      errFlag <= 1'b0;
    end else if (state == ST_RESET) begin
      if (bootDone) state <= ST_READY;
    end else if (ctrlWr) begin
      if (reqCode == ST_RESET) begin
        state   <= ST_RESET;
        errFlag <= 1'b0;
      end else if (reqCode == state) begin
        state <= state;
      end else if (moveLegal(state, reqCode)) begin
        state <= lpState_t'(reqCode);
      end else begin
        errFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lpwr_regs.sv
module lpwr_regs
  import lpwr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpStrobe_t         strobe,
  input  lpState_t          state,
  input  logic              errFlag,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  localparam int NCTX = (1 << ADDR_W) - 2;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  logic [DATA_W-1:0] ctxQ   [NCTX];
  logic [NCTX-1:0]   ctxHit;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] muxOut;

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    assign ctxHit[k] = (regAddr == ADDR_W'(k + 2));
    always_ff @(posedge clk) begin
      if (!rstN || strobe.ctxClr) ctxQ[k] <= '0;
      else if (strobe.ctxWe && ctxHit[k]) ctxQ[k] <= regWrData;
    end
  end

  always_comb begin
    statWord      = '0;
    statWord[2:0] = state;
    statWord[3]   = errFlag;
    statWord[4]   = (state == ST_ACT);
  end

  always_comb begin
    muxOut = '0;
    if (regAddr == STAT_ADDR) muxOut = statWord;
    for (int k = 0; k < NCTX; k++) begin
      if (ctxHit[k]) muxOut = ctxQ[k];
    end
  end

  assign regRdData = (regRdEn && strobe.rdOpen) ? muxOut : '0;

endmodule

// File: rtl/lpwr_state_ctrl.sv
module lpwr_state_ctrl
  import lpwr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootDone,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              xferReq,
  output logic              xferGrant,
  output logic [2:0]        curState,
  output logic              errFlag
);

  lpState_t  state;
  lpStrobe_t strobe;

  lpwr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rstN(rstN), .bootDone(bootDone), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .xferReq(xferReq),
    .state(state), .errFlag(errFlag), .xferGrant(xferGrant), .strobe(strobe)
  );

  lpwr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .state(state), .errFlag(errFlag),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  assign curState = state;

endmodule

// File: rtl/lpwr_state_ctrl_chk.sv
module lpwr_state_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              xferReq,
  input logic              xferGrant,
  input logic [2:0]        curState,
  input logic              errFlag
);

  logic ctrlWr;
  logic rstReq;
  assign ctrlWr = regWrEn && (regAddr == '0) && (curState != 3'd0);
  assign rstReq = ctrlWr && (regWrData[2:0] == 3'd0);

  a_r2_leave_reset_only_to_ready: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 3'd0) |=> (curState == 3'd0 || curState == 3'd1));

  a_r4_reset_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 3'd0 && regRdEn) |-> (regRdData == '0));

  a_r6_illegal_from_ready: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && curState == 3'd1 && regWrData[2:0] >= 3'd3) |=> (errFlag && curState == 3'd1));

  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !rstReq) |=> errFlag);

  a_r8_reset_request: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> (curState == 3'd0 && !errFlag));

  a_r10_grant_only_active: assert property (@(posedge clk) disable iff (!rstN)
    xferGrant |-> (xferReq && curState == 3'd2));

  a_r5_state_code_valid: assert property (@(posedge clk) disable iff (!rstN)
    curState <= 3'd5);

endmodule

bind lpwr_state_ctrl lpwr_state_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .xferReq(xferReq),
  .xferGrant(xferGrant), .curState(curState), .errFlag(errFlag)
);

// File: tb/lpwr_state_ctrl_test.sv
`timescale 1ns/1ps
module lpwr_state_ctrl_test;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              bootDone = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              xferReq = 1'b0;
  logic              xferGrant;
  logic [2:0]        curState;
  logic              errFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpwr_state_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .bootDone(bootDone), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .xferReq(xferReq), .xferGrant(xferGrant),
    .curState(curState), .errFlag(errFlag)
  );

  function automatic bit legalMove(int fromSt, int toCode);
    case (fromSt)
      1: return toCode == 2;
      2: return toCode == 3 || toCode == 4 || toCode == 5;
      3: return toCode == 2 || toCode == 5;
      4: return toCode == 2 || toCode == 5;
      5: return toCode == 2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    regAddr = ADDR_W'(addr);
    regWrData = DATA_W'(data);
    regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(int addr, output int val);
    regAddr = ADDR_W'(addr);
    regRdEn = 1'b1;
    #0.5;
    val = int'(regRdData);
    regRdEn = 1'b0;
  endtask

  task automatic hardReset();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  task automatic boot();
    bootDone = 1'b1;
    tick();
    bootDone = 1'b0;
  endtask

  task automatic goTo(int s);
    if (curState != 3'd0) wr(0, 0);
    if (s == 0) return;
    boot();
    if (s >= 2) wr(0, 2);
    if (s >= 3) wr(0, s);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    @(negedge clk);
    rstN = 1'b0;
    xferReq = 1'b1;
    tick();
    tick();
    // R1 during reset
    check(curState == 3'd0 && errFlag == 1'b0 && xferGrant == 1'b0, "R1 in reset",
          {curState, errFlag, xferGrant}, 0);
    rstN = 1'b1;
    tick();
    rd(1, v);
    check(v == 0 && curState == 3'd0, "R1 after release", v, 0);

    // R2: hold boot low
    for (int i = 0; i < 5; i++) tick();
    check(curState == 3'd0, "R2 stays reset without boot", curState, 0);

    // R3: writes in reset dropped
    wr(0, 2);
    check(curState == 3'd0 && errFlag == 1'b0, "R3 control write dropped", {curState, errFlag}, 0);
    wr(2, 8'h77);
    // R4 reads zero in reset
    regAddr = 2'd2;
    regRdEn = 1'b1;
    #0.5;
    check(regRdData == 8'h00, "R4 reset read", regRdData, 0);
    regRdEn = 1'b0;
    boot();
    check(curState == 3'd1, "R2 boot to ready", curState, 1);
    rd(2, v);
    check(v == 0, "R3 reset-time context write dropped", v, 0);

    // R12 handshake with R9 programming
    rd(1, v);
    check(v == 8'h01, "R11 status ready", v, 8'h01);
    wr(2, 8'hA5);
    wr(3, 8'h3C);
    rd(2, v);
    check(v == 8'hA5, "R9 ready write ctx2", v, 8'hA5);
    rd(3, v);
    check(v == 8'h3C, "R9 ready write ctx3", v, 8'h3C);
    wr(0, 2);
    rd(1, v);
    check(v == 8'h12, "R12 status reports active", v, 8'h12);
    rd(0, v);
    check(v == 0, "R11 control reads zero", v, 0);
    wr(2, 8'h5A);
    rd(2, v);
    check(v == 8'h5A, "R9 active write ctx2", v, 8'h5A);
    wr(0, 3);
    wr(3, 8'hFF);
    rd(3, v);
    check(v == 8'h3C, "R9 suspended write dropped", v, 8'h3C);
    rd(2, v);
    check(v == 8'h5A, "R9 suspended read", v, 8'h5A);
    wr(0, 4);
    check(curState == 3'd3 && errFlag == 1'b1, "R6 suspended to low-power illegal",
          {curState, errFlag}, {3'd3, 1'b1});
    wr(0, 2);
    rd(1, v);
    check(v == 8'h1A && errFlag == 1'b1, "R7 error sticky through legal move", v, 8'h1A);
    wr(0, 0);
    check(curState == 3'd0 && errFlag == 1'b0, "R8 reset request", {curState, errFlag}, 0);
    boot();
    rd(2, v);
    check(v == 0, "R8 ctx2 cleared", v, 0);
    rd(3, v);
    check(v == 0, "R8 ctx3 cleared", v, 0);

    // R7 cleared by rstN
    wr(0, 4);
    check(errFlag == 1'b1, "R6 ready to low-power illegal", errFlag, 1);
    hardReset();
    check(errFlag == 1'b0, "R7 cleared by rstN", errFlag, 0);

    // Sweep: R5 R6 R8 R10
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 8; c++) begin
        int expSt;
        int expErr;
        hardReset();
        goTo(s);
        check(curState == 3'(s), "R5 reach start state", curState, s);
        check(xferGrant == (s == 2), "R10 grant per state", xferGrant, (s == 2));
        expErr = 0;
        if (s == 0) expSt = 0;
        else if (c == 0) expSt = 0;
        else if (c == s) expSt = s;
        else if (legalMove(s, c)) expSt = c;
        else begin
          expSt = s;
          expErr = 1;
        end
        wr(0, c);
        check(curState == 3'(expSt) && errFlag == expErr[0], "R5 R6 R8 sweep",
              {curState, errFlag}, {3'(expSt), expErr[0]});
      end
    end

    xferReq = 1'b0;
    hardReset();
    goTo(2);
    check(xferGrant == 1'b0, "R10 no request no grant", xferGrant, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule